// File: doc/BRIEF.md
# UART Receive FIFO with Line Status

This block is the part of a UART receiver that sits behind the bit deserializer. Each completed character arrives as a one-cycle strobe. The strobe carries the data byte and three error tags: break, framing error and parity error. The byte and its tags are stored together in a 16-entry first-in first-out queue. The CPU sees the oldest byte on `data_out` and removes it with a data-read strobe.

A line status word reports several conditions:
- whether data is waiting;
- an overrun, reported at once when a character arrives while the queue is full;
- the error tags of the character now at the queue head.

Once head tags have been observed, they stay sticky until the CPU reads the status word. A receiver line status interrupt is raised while any error bit is set and the interrupt-enable input is high. A status read clears the error bits and the interrupt. An error event that lands in the same cycle as a status read is kept.

Top module: `uart_rx_lsr`

## Requirements
- R1: `line_status[0]` (data ready) is 1 from the cycle after a character is pushed into an empty queue. It returns to 0 in the cycle after the last entry is popped by `data_rd`.
- R2: When `rx_valid` arrives while the queue holds 16 entries and `data_rd` is low, `line_status[1]` (overrun) is set in the next cycle. The new character is discarded, and the queue contents and head byte are unchanged.
- R3: Characters leave the queue in arrival order. `data_out` always shows the byte at the head, and up to 16 characters are held.
- R4: The tags are reported at these status bit positions: parity error at `line_status[2]`, framing error at bit 3, break at bit 4. A character's tags appear one cycle after that character reaches the head, which is two cycles after a push into an empty queue. A character that is not at the head never shows its tags.
- R5: Error bits 4:2, once set, stay set after the character that caused them is popped. They stay set until the next status read.
- R6: A `status_rd` strobe clears `line_status[4:1]` in the next cycle. Data ready is not affected, and bits 7:5 always read 0.
- R7: `rls_irq` is 1 exactly while `rls_int_en` is 1 and any of `line_status[4:1]` is 1. It falls in the cycle after a status read that clears those bits.
- R8: If a status read coincides with a new overrun, or with the first capture of a head character's tags, the new error is kept and the bit reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a character has been received |
| rx_byte | input | 8 | Received data byte |
| rx_break | input | 1 | Break detected for this character |
| rx_frame_err | input | 1 | Framing error for this character |
| rx_parity_err | input | 1 | Parity error for this character |
| data_rd | input | 1 | CPU read of the data register; pops the head |
| status_rd | input | 1 | CPU read of the line status word; clears error bits |
| rls_int_en | input | 1 | Enable for the receiver line status interrupt |
| data_out | output | 8 | Byte at the queue head |
| line_status | output | 8 | Line status word |
| rls_irq | output | 1 | Receiver line status interrupt |

## Verification
A status read can fall in the same cycle as either of two error events. One is an overrun from a character arriving at a full queue. The other is the first capture of a freshly exposed head character's tags. The bench fills the queue to 16 entries and then drives `rx_valid` and `status_rd` together. Separately, it pushes a tagged character into an empty queue and drives `status_rd` in exactly the cycle its tags are captured. In both cases the bench judges the outcome by the relevant status bit staying 1 afterwards, and then by a plain status read clearing it.

// File: rtl/uart_rx_pkg.sv
// Shared types for the UART receive queue: the stored character entry and
// the bit positions of the line status word.
package uart_rx_pkg;
    localparam int DATA_W = 8;

    localparam int ST_READY  = 0;
    localparam int ST_OVR    = 1;
    localparam int ST_PARITY = 2;
    localparam int ST_FRAME  = 3;
    localparam int ST_BREAK  = 4;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [DATA_W-1:0] data;
    } rx_char_t;

    localparam int ENTRY_W = $bits(rx_char_t);
endpackage

// File: rtl/rx_fifo.sv
// Synchronous first-in first-out queue of WIDTH-bit entries.
// Assumes DEPTH is a power of two and at least 2. A push while full is
// accepted only when a pop happens in the same cycle. A pop while empty
// is ignored. rdata shows the head entry combinationally.
module rx_fifo #(
    parameter int WIDTH = 11,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign rdata   = mem[rd_ptr];

    // Storage write; entries need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rx_err_track.sv
// Sticky error tracking for the receive line status.
// Captures the head entry's tags once per head character: a capture marks
// the head as taken until the head changes. Keeps an overrun flag. A status
// read clears all sticky bits, but an event in the same cycle still sets
// its bit.
module rx_err_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       head_valid,
    input  logic [2:0] head_tags,    // {break, framing, parity}
    input  logic       head_pop,
    input  logic       ovr_evt,
    input  logic       status_rd,
    output logic [2:0] err_sticky,   // {break, framing, parity}
    output logic       ovr_sticky,
    output logic       head_taken
);
    logic capture;

    assign capture = head_valid && !head_taken;

    // Mark whether the current head's tags are already in the sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n)        head_taken <= 1'b0;
        else if (head_pop) head_taken <= 1'b0;
        else if (capture)  head_taken <= 1'b1;
    end

    // Sticky tag bits: cleared by a status read, set by a capture.
    always_ff @(posedge clk) begin
        if (!rst_n) err_sticky <= '0;
        else        err_sticky <= (status_rd ? 3'b000 : err_sticky)
                                  | (capture ? head_tags : 3'b000);
    end

    // Overrun flag: cleared by a status read, set by an overrun event.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_sticky <= 1'b0;
        else        ovr_sticky <= (ovr_sticky && !status_rd) || ovr_evt;
    end
endmodule

// File: rtl/uart_rx_lsr.sv
// Receive queue with line status and line status interrupt.
// Assumes rx_valid, data_rd and status_rd are single-cycle strobes.
// Each character is stored with its error tags. Tags reach the status word
// only after the character becomes the queue head. An overrun drops the
// arriving character.
module uart_rx_lsr
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_break,
    input  logic              rx_frame_err,
    input  logic              rx_parity_err,
    input  logic              data_rd,
    input  logic              status_rd,
    input  logic              rls_int_en,
    output logic [DATA_W-1:0] data_out,
    output logic [7:0]        line_status,
    output logic              rls_irq
);
    rx_char_t          in_char, head_char;
    logic [ENTRY_W-1:0] head_raw;
    logic [CW-1:0]     fifo_count;
    logic              fifo_empty, fifo_full;
    logic              ovr_evt;
    logic [2:0]        err_sticky;
    logic              ovr_sticky, head_taken;

    // Pack the incoming character with its tags.
    always_comb begin
        in_char      = '0;
        in_char.data = rx_byte;
        in_char.brk  = rx_break;
        in_char.frm  = rx_frame_err;
        in_char.par  = rx_parity_err;
    end

    assign ovr_evt   = rx_valid && fifo_full && !data_rd;
    assign head_char = rx_char_t'(head_raw);

    rx_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_valid),
        .wdata (in_char),
        .pop   (data_rd),
        .rdata (head_raw),
        .count (fifo_count),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    rx_err_track u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (!fifo_empty),
        .head_tags  ({head_char.brk, head_char.frm, head_char.par}),
        .head_pop   (data_rd && !fifo_empty),
        .ovr_evt    (ovr_evt),
        .status_rd  (status_rd),
        .err_sticky (err_sticky),
        .ovr_sticky (ovr_sticky),
        .head_taken (head_taken)
    );

    // Assemble the status word and the interrupt.
    always_comb begin
        line_status            = '0;
        line_status[ST_READY]  = !fifo_empty;
        line_status[ST_OVR]    = ovr_sticky;
        line_status[ST_PARITY] = err_sticky[0];
        line_status[ST_FRAME]  = err_sticky[1];
        line_status[ST_BREAK]  = err_sticky[2];
        data_out               = head_char.data;
        rls_irq                = rls_int_en && (ovr_sticky || (|err_sticky));
    end
endmodule

// File: rtl/uart_rx_lsr_chk.sv
// Property checker for uart_rx_lsr, attached by bind. Observes ports and
// the queue occupancy flags and head-capture state of the top module.
module uart_rx_lsr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       data_rd,
    input logic       status_rd,
    input logic       rls_int_en,
    input logic [7:0] data_out,
    input logic [7:0] line_status,
    input logic       rls_irq,
    input logic       fifo_empty,
    input logic       fifo_full,
    input logic       head_taken
);
    a_r1_ready_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && fifo_empty |=> line_status[0]);

    a_r2_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && fifo_full && !data_rd |=> line_status[1] && fifo_full);

    a_r2_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && fifo_full && !data_rd |=> data_out == $past(data_out));

    a_r4_tags_need_head: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_status[2]) |-> $past(!fifo_empty));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd && !rx_valid && (fifo_empty || head_taken)
        |=> line_status[4:1] == 4'b0000);

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !rls_int_en |-> !rls_irq);

    a_r8_overrun_wins: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd && rx_valid && fifo_full && !data_rd |=> line_status[1]);

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        line_status[7:5] == 3'b000);
endmodule

bind uart_rx_lsr uart_rx_lsr_chk u_chk (.*);

// File: tb/uart_rx_lsr_test.sv
// Self-checking bench for uart_rx_lsr: a table walk, then directed tests.
module uart_rx_lsr_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0] op;     // 0 push, 1 data read, 2 status read
        logic [7:0] d;
        logic [2:0] tags;   // {break, framing, parity}
        logic [7:0] st;
        logic       irq;
        logic [7:0] dout;
    } row_t;

    localparam int NROWS = 10;
    localparam row_t ROWS [NROWS] = '{
        '{2'd0, 8'h41, 3'b000, 8'h01, 1'b0, 8'h41},
        '{2'd0, 8'h42, 3'b001, 8'h01, 1'b0, 8'h41},
        '{2'd1, 8'h00, 3'b000, 8'h05, 1'b1, 8'h42},
        '{2'd2, 8'h00, 3'b000, 8'h01, 1'b0, 8'h42},
        '{2'd1, 8'h00, 3'b000, 8'h00, 1'b0, 8'h00},
        '{2'd0, 8'h55, 3'b010, 8'h09, 1'b1, 8'h55},
        '{2'd0, 8'h66, 3'b100, 8'h09, 1'b1, 8'h55},
        '{2'd1, 8'h00, 3'b000, 8'h19, 1'b1, 8'h66},
        '{2'd1, 8'h00, 3'b000, 8'h18, 1'b1, 8'h00},
        '{2'd2, 8'h00, 3'b000, 8'h00, 1'b0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_break = 1'b0, rx_frame_err = 1'b0, rx_parity_err = 1'b0;
    logic       data_rd = 1'b0, status_rd = 1'b0, rls_int_en = 1'b1;
    logic [7:0] data_out, line_status;
    logic       rls_irq;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_lsr uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_break(rx_break), .rx_frame_err(rx_frame_err),
        .rx_parity_err(rx_parity_err), .data_rd(data_rd),
        .status_rd(status_rd), .rls_int_en(rls_int_en),
        .data_out(data_out), .line_status(line_status), .rls_irq(rls_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive strobes for one clock edge, then release them at the next negedge.
    task automatic drive(input logic v, input logic [7:0] d, input logic [2:0] t,
                         input logic rdd, input logic rds);
        rx_valid = v; rx_byte = d;
        {rx_break, rx_frame_err, rx_parity_err} = t;
        data_rd = rdd; status_rd = rds;
        @(negedge clk);
        rx_valid = 1'b0; data_rd = 1'b0; status_rd = 1'b0;
        {rx_break, rx_frame_err, rx_parity_err} = 3'b000;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk("R6 reset status", line_status, 8'h00);
        chk("R7 reset irq", rls_irq, 1'b0);
        rst_n = 1'b1;
        idle();

        // Table walk: R1 R3 R4 R5 R6 R7.
        for (int i = 0; i < NROWS; i++) begin
            drive(ROWS[i].op == 2'd0, ROWS[i].d, ROWS[i].tags,
                  ROWS[i].op == 2'd1, ROWS[i].op == 2'd2);
            idle();
            chk($sformatf("R1 R4 R5 R6 row %0d status", i), line_status, ROWS[i].st);
            chk($sformatf("R7 row %0d irq", i), rls_irq, ROWS[i].irq);
            if (ROWS[i].st[0])
                chk($sformatf("R3 row %0d head", i), data_out, ROWS[i].dout);
        end

        // R2 and R3: fill to 16 entries, then overflow.
        for (int k = 0; k < 16; k++) drive(1'b1, 8'h10 + 8'(k), 3'b000, 1'b0, 1'b0);
        chk("R3 full no error", line_status, 8'h01);
        drive(1'b1, 8'hEE, 3'b111, 1'b0, 1'b0);
        chk("R2 overrun set", line_status, 8'h03);
        chk("R2 head kept", data_out, 8'h10);
        chk("R7 irq on overrun", rls_irq, 1'b1);
        rls_int_en = 1'b0;
        #1;
        chk("R7 irq gated off", rls_irq, 1'b0);
        rls_int_en = 1'b1;
        drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        chk("R6 overrun cleared", line_status, 8'h01);
        for (int k = 0; k < 16; k++) begin
            chk("R3 order", data_out, 8'h10 + 8'(k));
            drive(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
        end
        idle();
        chk("R2 dropped char absent, R1 empty", line_status, 8'h00);

        // R8: overrun in the same cycle as a status read.
        for (int k = 0; k < 16; k++) drive(1'b1, 8'(k), 3'b000, 1'b0, 1'b0);
        drive(1'b1, 8'hAA, 3'b000, 1'b0, 1'b1);
        chk("R8 overrun beats read", line_status[1], 1'b1);
        drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        chk("R6 later read clears", line_status[1], 1'b0);
        for (int k = 0; k < 16; k++) drive(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
        idle();
        chk("R1 drained", line_status[0], 1'b0);

        // R8: head tag capture in the same cycle as a status read.
        drive(1'b1, 8'h77, 3'b010, 1'b0, 1'b0);
        drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        idle();
        chk("R8 capture beats read", line_status, 8'h09);
        drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        idle();
        chk("R6 clear after capture", line_status, 8'h01);

        // R4: tags of a non-head character are not reported.
        drive(1'b1, 8'h78, 3'b100, 1'b0, 1'b0);
        idle();
        chk("R4 buried break hidden", line_status, 8'h01);

        done = 1'b1;
        finish_run();
    end
endmodule